// File: doc/BRIEF.md
# (4,2) Compressor-Tree Unsigned Multiplier

This block multiplies two unsigned operands of `WIDTH` bits each and returns the full product of `2*WIDTH` bits. It has no clock and no state. The output follows the inputs combinationally, so a surrounding pipeline registers it where timing requires.

The block works in three steps:

- An AND grid builds one shifted partial-product row for every multiplier bit.
- The rows are taken in groups of four. Each group goes through a row of tiled (4,2) counters, which turns four rows into two. Each counter is built from two cascaded full adders and passes an internal carry sideways to the counter one column to its left.
- Levels of such rows repeat until only two rows are left. A parallel-prefix carry-propagate adder then sums those two rows.

Every row in the tree spans the full `2*WIDTH` product width. Counter inputs that no partial-product bit reaches are tied to 0, and carries that leave the top column are dropped. This is safe because the true product always fits in `2*WIDTH` bits.

`WIDTH` must be a power of two of at least 4. The default is 8, and 4 is the other supported size. An 8-bit instance has two counter levels and a 4-bit instance has one.

Top module: `umul_c42_tree`

## Requirements
- R1: For every pair of operand values, `product_o` equals the arithmetic product `mcand_i * mplier_i`, zero-extended to `2*WIDTH` bits.
- R2: If either operand is zero, `product_o` is zero.
- R3: With a multiplier of 1, `product_o` equals the multiplicand with its upper `WIDTH` bits zero. With a multiplicand of 1, it equals the multiplier.
- R4: With both operands at their largest value, `product_o` is `2^(2*WIDTH) - 2^(WIDTH+1) + 1`. For the default size this is 0xFE01.
- R5: The partial-product bit at column `i+j` of row `i` is the AND of multiplicand bit `j` and multiplier bit `i`. Hence the number of set bits over all rows equals the popcount of the multiplicand times the popcount of the multiplier.
- R6: Each (4,2) counter conserves weight. Its four external inputs plus its lateral carry-in, all of weight 1, equal its sum (weight 1) plus twice its external carry and its lateral carry-out (each weight 2). The lateral carry-out depends only on the first three external inputs.
- R7: Each counter row maps four input rows to a sum row and a carry row shifted up by one column, with the same total modulo `2^(2*WIDTH)`. Column 0 takes a lateral carry-in of 0.
- R8: The final adder propagates carries across the whole product width. A product of two powers of two `2^i * 2^j` sets only bit `i+j`.
- R9: The block works unchanged at `WIDTH = 4`, giving the correct 8-bit product for every operand pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mcand_i | input | WIDTH | Multiplicand, unsigned |
| mplier_i | input | WIDTH | Multiplier, unsigned; bit i gates partial-product row i |
| product_o | output | 2*WIDTH | Full-width unsigned product |

## Verification
The default instance is exercised on the full operand space and the 4-bit instance on all 256 pairs, so every counter column and lateral-carry path sees every combination it can receive. Directed patterns are applied in addition:

- Zero operands show whether stray carries are created from nothing.
- Multiplying by one shows whether a single row passes through the tree unaltered.
- Maximum operands drive carries into the top product bit.
- Single-bit products reveal misplaced column weights.
- Alternating-bit operands stress lateral carries between neighbouring counters.

// File: rtl/umul_c42_pkg.sv
package umul_c42_pkg;

    typedef struct packed {
        logic sum;
        logic carry;
    } fa_out_t;

    // (3,2) counter: three bits of equal weight in, sum and carry out
    function automatic fa_out_t full_add(input logic x, input logic y, input logic z);
        fa_out_t r;
        r.sum   = x ^ y ^ z;
        r.carry = (x & y) | (x & z) | (y & z);
        return r;
    endfunction

    // first row index of reduction level lv in the flat row store
    function automatic int level_base(input int n, input int lv);
        return 2 * n - 2 * (n >> lv);
    endfunction

endpackage

// File: rtl/umul_pp_grid.sv
module umul_pp_grid #(
    parameter int WIDTH = 8,
    localparam int PW   = 2 * WIDTH
) (
    input  logic [WIDTH-1:0]          mcand_i,
    input  logic [WIDTH-1:0]          mplier_i,
    output logic [WIDTH-1:0][PW-1:0]  pp_o
);

    logic [WIDTH-1:0][PW-1:0] pp_d;

    always_comb begin
        pp_d = '0;
        for (int r = 0; r < WIDTH; r++) begin
            for (int c = 0; c < WIDTH; c++) begin
                pp_d[r][r + c] = mcand_i[c] & mplier_i[r];
            end
        end
    end

    assign pp_o = pp_d;

    // R5
    always_comb begin
        pp_population_chk: assert ($countones(pp_d) ==
                                   $countones(mcand_i) * $countones(mplier_i))
            else $error("partial product population mismatch");
    end

endmodule

// File: rtl/umul_c42_row.sv
module umul_c42_row
    import umul_c42_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [3:0][W-1:0] rows_i,
    output logic [W-1:0]      sum_o,
    output logic [W-1:0]      carry_o
);

    logic [W-1:0] sum_d;
    logic [W-1:0] carry_d;

    always_comb begin
        logic    lat;
        logic    lat_in;
        fa_out_t upper;
        fa_out_t lower;
        logic [W-1:0] ext;
        logic [W-1:0] tot_in;
        logic [W-1:0] tot_out;

        lat = 1'b0;
        ext = '0;
        for (int c = 0; c < W; c++) begin
            lat_in   = lat;
            upper    = full_add(rows_i[0][c], rows_i[1][c], rows_i[2][c]);
            lower    = full_add(upper.sum, rows_i[3][c], lat_in);
            sum_d[c] = lower.sum;
            ext[c]   = lower.carry;
            lat      = upper.carry;
            // R6
            cell_weight_chk: assert (int'(rows_i[0][c]) + int'(rows_i[1][c]) +
                                     int'(rows_i[2][c]) + int'(rows_i[3][c]) +
                                     int'(lat_in) ==
                                     int'(lower.sum) +
                                     2 * (int'(lower.carry) + int'(upper.carry)))
                else $error("counter weight not conserved in column %0d", c);
        end
        carry_d = {ext[W-2:0], 1'b0};

        tot_in  = rows_i[0] + rows_i[1] + rows_i[2] + rows_i[3];
        tot_out = sum_d + carry_d;
        // R7
        row_total_chk: assert (tot_in == tot_out)
            else $error("counter row changed the row total");
    end

    assign sum_o   = sum_d;
    assign carry_o = carry_d;

endmodule

// File: rtl/umul_prefix_cpa.sv
module umul_prefix_cpa #(
    parameter int W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] sum_o
);

    logic [W-1:0] sum_d;

    always_comb begin
        logic [W-1:0] gen_v;
        logic [W-1:0] prop_v;
        logic [W-1:0] half_v;
        logic [W-1:0] ref_v;

        half_v = a_i ^ b_i;
        gen_v  = a_i & b_i;
        prop_v = half_v;
        for (int d = 1; d < W; d = d * 2) begin
            gen_v  = gen_v | (prop_v & (gen_v << d));
            prop_v = prop_v & ((prop_v << d) | ((W)'(1) << d) - (W)'(1));
        end
        sum_d = half_v ^ {gen_v[W-2:0], 1'b0};

        ref_v = a_i + b_i;
        // R8
        cpa_sum_chk: assert (sum_d == ref_v)
            else $error("prefix adder result mismatch");
    end

    assign sum_o = sum_d;

endmodule

// File: rtl/umul_c42_tree.sv
module umul_c42_tree
    import umul_c42_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0]   mcand_i,
    input  logic [WIDTH-1:0]   mplier_i,
    output logic [2*WIDTH-1:0] product_o
);

    localparam int PW        = 2 * WIDTH;
    localparam int LEVELS    = $clog2(WIDTH) - 1;
    localparam int ROW_TOTAL = 2 * WIDTH - 2;
    localparam int FINAL_ROW = 2 * WIDTH - 4;

    logic [WIDTH-1:0][PW-1:0] pp_q;
    logic [PW-1:0]            rows [ROW_TOTAL];

    umul_pp_grid #(.WIDTH(WIDTH)) u_grid (
        .mcand_i  (mcand_i),
        .mplier_i (mplier_i),
        .pp_o     (pp_q)
    );

    for (genvar r = 0; r < WIDTH; r++) begin : g_seed
        assign rows[r] = pp_q[r];
    end

    for (genvar lv = 0; lv < LEVELS; lv++) begin : g_level
        localparam int IN_BASE  = level_base(WIDTH, lv);
        localparam int OUT_BASE = level_base(WIDTH, lv + 1);
        localparam int GROUPS   = (WIDTH >> lv) / 4;
        for (genvar g = 0; g < GROUPS; g++) begin : g_group
            umul_c42_row #(.W(PW)) u_row (
                .rows_i  ({rows[IN_BASE + 4*g + 3], rows[IN_BASE + 4*g + 2],
                           rows[IN_BASE + 4*g + 1], rows[IN_BASE + 4*g]}),
                .sum_o   (rows[OUT_BASE + 2*g]),
                .carry_o (rows[OUT_BASE + 2*g + 1])
            );
        end
    end

    umul_prefix_cpa #(.W(PW)) u_cpa (
        .a_i   (rows[FINAL_ROW]),
        .b_i   (rows[FINAL_ROW + 1]),
        .sum_o (product_o)
    );

endmodule

// File: tb/umul_c42_tree_tb.sv
module umul_c42_tree_tb;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [7:0]  a8, b8;
    logic [15:0] p8;
    logic [3:0]  a4, b4;
    logic [7:0]  p4;

    umul_c42_tree #(.WIDTH(8)) u_dut (.mcand_i(a8), .mplier_i(b8), .product_o(p8));
    umul_c42_tree #(.WIDTH(4)) u_dut4 (.mcand_i(a4), .mplier_i(b4), .product_o(p4));

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run8(input logic [7:0] a, input logic [7:0] b, input string req,
                        input logic [15:0] exp);
        @(posedge clk);
        a8 = a;
        b8 = b;
        @(negedge clk);
        chk(req, p8, exp);
    endtask

    task automatic t_zero();
        run8(8'h00, 8'h00, "R2 both zero", 16'h0000);
        run8(8'hFF, 8'h00, "R2 multiplier zero", 16'h0000);
        run8(8'h00, 8'hB7, "R2 multiplicand zero", 16'h0000);
    endtask

    task automatic t_identity();
        run8(8'hC3, 8'h01, "R3 multiplier one", 16'h00C3);
        run8(8'h01, 8'h5A, "R3 multiplicand one", 16'h005A);
        run8(8'hFF, 8'h01, "R3 all-ones times one", 16'h00FF);
    endtask

    task automatic t_max();
        run8(8'hFF, 8'hFF, "R4 maximum operands", 16'hFE01);
    endtask

    task automatic t_powers();
        for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < 8; j++) begin
                run8(8'(1 << i), 8'(1 << j), "R8 single-bit product", 16'(1 << (i + j)));
            end
        end
    endtask

    task automatic t_alternating();
        run8(8'hAA, 8'h55, "R7 alternating bits", 16'h3872);
        run8(8'h55, 8'hFF, "R7 alternating by ones", 16'h54AB);
        run8(8'hF0, 8'h0F, "R7 split nibbles", 16'h0E10);
    endtask

    task automatic t_full8();
        for (int a = 0; a < 256; a++) begin
            for (int b = 0; b < 256; b++) begin
                run8(8'(a), 8'(b), "R1 R5 R6 exhaustive 8-bit", 16'(a * b));
            end
        end
    endtask

    task automatic t_full4();
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                @(posedge clk);
                a4 = 4'(a);
                b4 = 4'(b);
                @(negedge clk);
                chk("R9 exhaustive 4-bit", {8'h00, p4}, 16'(a * b));
            end
        end
    endtask

    initial begin
        a8 = '0; b8 = '0; a4 = '0; b4 = '0;
        @(negedge clk);
        chk("R2 idle zero state", p8, 16'h0000);
        t_zero();
        t_identity();
        t_max();
        t_powers();
        t_alternating();
        t_full4();
        t_full8();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule